// File: doc/BRIEF.md
# Pipeline Stage Register Chain

This block holds the program counter and the four inter-stage registers of a five-stage, 32-bit, single-issue pipeline. These are the fetch/decode, decode/execute, execute/memory and memory/writeback registers. The fetch stage chooses the next PC. It is either the current PC plus the step, or a branch target supplied from outside. The fetch stage also hands the fetched word and its incremented PC to decode. Each later register captures the datapath fields of the stage in front of it. Each also captures the control bits that are still needed further down the pipe.

Control bits are grouped by the stage that consumes them:
- The execute group (destination select, ALU operation, ALU operand select) lives only in the decode/execute register.
- The memory group (branch, memory read, memory write) rides one stage further.
- The writeback group (memory-to-register select, register write) rides all the way to the last register.

The destination register number and the PC travel with the instruction, so writeback always uses the number that belongs to the retiring instruction.

Each register has a synchronous enable that holds it for a stall. Each also has a synchronous flush that turns its slot into a bubble with no side effects. The surrounding pipeline drives these from its hazard logic. The ALU, register file, memories, decode and branch resolution sit outside the block.

Top module: `pipeRegChain`

## Requirements
- R1: On a clock edge with `pcEn` high, `pcOut` becomes `branchTarget` when `pcSrc` is high, and otherwise `pcOut + 4`. With `pcEn` low, `pcOut` holds.
- R2: On a clock edge with `ifIdEn` high and `ifIdFlush` low, `ifIdInstr` takes `fetchInstr` and `ifIdPc` takes `pcOut + 4`, both as seen before the edge. With `ifIdEn` low, `ifIdPc` holds.
- R3: On a clock edge with `idExEn` high, the decode/execute register loads its data fields: `idExRd1`, `idExRd2`, `idExImm` and `idExDest` from the decode inputs, and `idExPc` from `ifIdPc`.
- R4: On a clock edge with `exMemEn` high, the execute/memory register loads its data fields: `exMemTarget`, `exMemZero` and `exMemAluResult` from the execute inputs, `exMemWriteData` from `idExRd2`, and `exMemDest` from `idExDest`.
- R5: On a clock edge with `memWbEn` high, the memory/writeback register loads `memWbReadData` from `memReadData`, `memWbAluResult` from `exMemAluResult`, and `memWbDest` from `exMemDest`.
- R6: When loaded without a flush, each control group moves as follows:
  - decode/execute takes all nine decode control inputs;
  - execute/memory takes the memory and writeback groups from decode/execute;
  - memory/writeback takes the writeback group from execute/memory.
- R7: A register whose enable and flush are both low keeps every field, data and control, unchanged across the edge.
- R8: A high flush on the decode/execute, execute/memory or memory/writeback register zeroes all of that register's control bits at the next edge, whatever its enable. Its data fields still follow its enable.
- R9: A high `ifIdFlush` zeroes `ifIdInstr` at the next edge, whatever `ifIdEn`. In that same cycle `ifIdPc` still follows `ifIdEn`.
- R10: While `rstN` is low, `pcOut` is 0 and every field of every stage register, including all control bits and `ifIdInstr`, is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcEn | input | 1 | PC update enable |
| pcSrc | input | 1 | Select branch target as next PC |
| branchTarget | input | 32 | Branch target address |
| ifIdEn | input | 1 | Fetch/decode register enable |
| ifIdFlush | input | 1 | Fetch/decode bubble request |
| idExEn | input | 1 | Decode/execute register enable |
| idExFlush | input | 1 | Decode/execute bubble request |
| exMemEn | input | 1 | Execute/memory register enable |
| exMemFlush | input | 1 | Execute/memory bubble request |
| memWbEn | input | 1 | Memory/writeback register enable |
| memWbFlush | input | 1 | Memory/writeback bubble request |
| fetchInstr | input | 32 | Instruction word read at pcOut |
| idRd1 | input | 32 | First register read value |
| idRd2 | input | 32 | Second register read value |
| idImm | input | 32 | Sign-extended offset |
| idDest | input | 5 | Destination register number |
| idRegDst | input | 1 | Decoded destination select |
| idAluOp | input | 2 | Decoded ALU operation class |
| idAluSrc | input | 1 | Decoded ALU operand select |
| idBranch | input | 1 | Decoded branch flag |
| idMemRead | input | 1 | Decoded memory read |
| idMemWrite | input | 1 | Decoded memory write |
| idMemToReg | input | 1 | Decoded writeback source select |
| idRegWrite | input | 1 | Decoded register write |
| exTarget | input | 32 | Branch target from execute |
| exZero | input | 1 | ALU zero flag |
| exAluResult | input | 32 | ALU result |
| memReadData | input | 32 | Data memory read value |
| pcOut | output | 32 | Current PC |
| ifIdInstr | output | 32 | Instruction in decode |
| ifIdPc | output | 32 | Incremented PC in decode |
| idExRd1 | output | 32 | Read value 1 in execute |
| idExRd2 | output | 32 | Read value 2 in execute |
| idExImm | output | 32 | Offset in execute |
| idExPc | output | 32 | Incremented PC in execute |
| idExDest | output | 5 | Destination number in execute |
| idExRegDst | output | 1 | Destination select in execute |
| idExAluOp | output | 2 | ALU operation class in execute |
| idExAluSrc | output | 1 | ALU operand select in execute |
| idExBranch | output | 1 | Branch flag in execute |
| idExMemRead | output | 1 | Memory read in execute |
| idExMemWrite | output | 1 | Memory write in execute |
| idExMemToReg | output | 1 | Writeback source select in execute |
| idExRegWrite | output | 1 | Register write in execute |
| exMemTarget | output | 32 | Branch target in memory stage |
| exMemZero | output | 1 | Zero flag in memory stage |
| exMemAluResult | output | 32 | ALU result in memory stage |
| exMemWriteData | output | 32 | Store data in memory stage |
| exMemDest | output | 5 | Destination number in memory stage |
| exMemBranch | output | 1 | Branch flag in memory stage |
| exMemMemRead | output | 1 | Memory read in memory stage |
| exMemMemWrite | output | 1 | Memory write in memory stage |
| exMemMemToReg | output | 1 | Writeback source select in memory stage |
| exMemRegWrite | output | 1 | Register write in memory stage |
| memWbReadData | output | 32 | Loaded data in writeback |
| memWbAluResult | output | 32 | ALU result in writeback |
| memWbDest | output | 5 | Destination number in writeback |
| memWbMemToReg | output | 1 | Writeback source select in writeback |
| memWbRegWrite | output | 1 | Register write in writeback |

## Verification
The bench sweeps every combination of the ten PC and stage enable, flush and select inputs, twice over. Each combination carries different arithmetic data and control patterns, so every stage is seen loading, holding, flushing and flushing while held, next to neighbours in each of those states. After every edge the whole chain is compared with a model. The hold cases separate a register that keeps its value from one that reloads a look-alike. The flush-with-enable cases show that a bubble clears only the control bits while the data still moves. Control patterns that differ between groups expose any group that is dropped too early or routed from the wrong stage.

// File: rtl/pipeRegPkg.sv
package pipeRegPkg;

  typedef struct packed {
    logic       regDst;
    logic [1:0] aluOp;
    logic       aluSrc;
  } exCtrl_t;

  typedef struct packed {
    logic branch;
    logic memRead;
    logic memWrite;
  } memCtrl_t;

  typedef struct packed {
    logic memToReg;
    logic regWrite;
  } wbCtrl_t;

  typedef struct packed {
    exCtrl_t  ex;
    memCtrl_t mem;
    wbCtrl_t  wb;
  } idExCtrl_t;

  typedef struct packed {
    memCtrl_t mem;
    wbCtrl_t  wb;
  } exMemCtrl_t;

  // strobes from the control side to the datapath side
  typedef struct packed {
    logic pcLoad;
    logic ifIdLoad;
    logic ifIdZero;
    logic idExLoad;
    logic exMemLoad;
    logic memWbLoad;
  } stageStrobe_t;

endpackage

// File: rtl/stageReg.sv
module stageReg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    q <= '0;
    else if (clr) q <= '0;
    else if (en)  q <= d;
  end

endmodule

// File: rtl/pipeCtrlRegs.sv
module pipeCtrlRegs
  import pipeRegPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         pcEn,
  input  logic         ifIdEn,
  input  logic         ifIdFlush,
  input  logic         idExEn,
  input  logic         idExFlush,
  input  logic         exMemEn,
  input  logic         exMemFlush,
  input  logic         memWbEn,
  input  logic         memWbFlush,
  input  idExCtrl_t    decCtrl,
  output stageStrobe_t strobe,
  output idExCtrl_t    idExCtrl,
  output exMemCtrl_t   exMemCtrl,
  output wbCtrl_t      memWbCtrl
);

  localparam int IDEX_CW  = $bits(idExCtrl_t);
  localparam int EXMEM_CW = $bits(exMemCtrl_t);
  localparam int MEMWB_CW = $bits(wbCtrl_t);

  exMemCtrl_t exMemNext;
  wbCtrl_t    memWbNext;

  // drop the execute group after EX, the memory group after MEM
  assign exMemNext = '{mem: idExCtrl.mem, wb: idExCtrl.wb};
  assign memWbNext = exMemCtrl.wb;

  always_comb begin
    strobe.pcLoad    = pcEn;
    strobe.ifIdLoad  = ifIdEn;
    strobe.ifIdZero  = ifIdFlush;
    strobe.idExLoad  = idExEn;
    strobe.exMemLoad = exMemEn;
    strobe.memWbLoad = memWbEn;
  end

  stageReg #(.W(IDEX_CW)) u_idExCtl (
    .clk(clk), .rstN(rstN), .en(idExEn), .clr(idExFlush),
    .d(decCtrl), .q(idExCtrl)
  );

  stageReg #(.W(EXMEM_CW)) u_exMemCtl (
    .clk(clk), .rstN(rstN), .en(exMemEn), .clr(exMemFlush),
    .d(exMemNext), .q(exMemCtrl)
  );

  stageReg #(.W(MEMWB_CW)) u_memWbCtl (
    .clk(clk), .rstN(rstN), .en(memWbEn), .clr(memWbFlush),
    .d(memWbNext), .q(memWbCtrl)
  );

endmodule

// File: rtl/pipeDataRegs.sv
module pipeDataRegs
  import pipeRegPkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_W    = 5,
  parameter int PC_STEP  = 4,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobe_t     strobe,
  input  logic             pcSrc,
  input  logic [XLEN-1:0]  branchTarget,
  input  logic [XLEN-1:0]  fetchInstr,
  input  logic [XLEN-1:0]  idRd1,
  input  logic [XLEN-1:0]  idRd2,
  input  logic [XLEN-1:0]  idImm,
  input  logic [REG_W-1:0] idDest,
  input  logic [XLEN-1:0]  exTarget,
  input  logic             exZero,
  input  logic [XLEN-1:0]  exAluResult,
  input  logic [XLEN-1:0]  memReadData,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  ifIdInstr,
  output logic [XLEN-1:0]  ifIdPc,
  output logic [XLEN-1:0]  idExRd1,
  output logic [XLEN-1:0]  idExRd2,
  output logic [XLEN-1:0]  idExImm,
  output logic [XLEN-1:0]  idExPc,
  output logic [REG_W-1:0] idExDest,
  output logic [XLEN-1:0]  exMemTarget,
  output logic             exMemZero,
  output logic [XLEN-1:0]  exMemAluResult,
  output logic [XLEN-1:0]  exMemWriteData,
  output logic [REG_W-1:0] exMemDest,
  output logic [XLEN-1:0]  memWbReadData,
  output logic [XLEN-1:0]  memWbAluResult,
  output logic [REG_W-1:0] memWbDest
);

  localparam logic [XLEN-1:0] STEP   = XLEN'(PC_STEP);
  localparam logic [XLEN-1:0] PC_RST = XLEN'(RESET_PC);
  localparam int IDEX_W  = 4 * XLEN + REG_W;
  localparam int EXMEM_W = 3 * XLEN + 1 + REG_W;
  localparam int MEMWB_W = 2 * XLEN + REG_W;

  logic [XLEN-1:0]    pcPlusStep;
  logic [XLEN-1:0]    pcNext;
  logic [IDEX_W-1:0]  idExD,  idExQ;
  logic [EXMEM_W-1:0] exMemD, exMemQ;
  logic [MEMWB_W-1:0] memWbD, memWbQ;

  // next-PC select in the fetch stage
  assign pcPlusStep = pcOut + STEP;
  assign pcNext     = pcSrc ? branchTarget : pcPlusStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pcOut <= PC_RST;
    else if (strobe.pcLoad) pcOut <= pcNext;
  end

  stageReg #(.W(XLEN)) u_ifIdInstr (
    .clk(clk), .rstN(rstN), .en(strobe.ifIdLoad), .clr(strobe.ifIdZero),
    .d(fetchInstr), .q(ifIdInstr)
  );

  stageReg #(.W(XLEN)) u_ifIdPc (
    .clk(clk), .rstN(rstN), .en(strobe.ifIdLoad), .clr(1'b0),
    .d(pcPlusStep), .q(ifIdPc)
  );

  assign idExD = {idRd1, idRd2, idImm, ifIdPc, idDest};
  stageReg #(.W(IDEX_W)) u_idEx (
    .clk(clk), .rstN(rstN), .en(strobe.idExLoad), .clr(1'b0),
    .d(idExD), .q(idExQ)
  );
  assign {idExRd1, idExRd2, idExImm, idExPc, idExDest} = idExQ;

  assign exMemD = {exTarget, exZero, exAluResult, idExRd2, idExDest};
  stageReg #(.W(EXMEM_W)) u_exMem (
    .clk(clk), .rstN(rstN), .en(strobe.exMemLoad), .clr(1'b0),
    .d(exMemD), .q(exMemQ)
  );
  assign {exMemTarget, exMemZero, exMemAluResult, exMemWriteData, exMemDest} = exMemQ;

  assign memWbD = {memReadData, exMemAluResult, exMemDest};
  stageReg #(.W(MEMWB_W)) u_memWb (
    .clk(clk), .rstN(rstN), .en(strobe.memWbLoad), .clr(1'b0),
    .d(memWbD), .q(memWbQ)
  );
  assign {memWbReadData, memWbAluResult, memWbDest} = memWbQ;

endmodule

// File: rtl/pipeRegChain.sv
module pipeRegChain
  import pipeRegPkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REG_W    = 5,
  parameter int PC_STEP  = 4,
  parameter int RESET_PC = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pcEn,
  input  logic             pcSrc,
  input  logic [XLEN-1:0]  branchTarget,
  input  logic             ifIdEn,
  input  logic             ifIdFlush,
  input  logic             idExEn,
  input  logic             idExFlush,
  input  logic             exMemEn,
  input  logic             exMemFlush,
  input  logic             memWbEn,
  input  logic             memWbFlush,
  input  logic [XLEN-1:0]  fetchInstr,
  input  logic [XLEN-1:0]  idRd1,
  input  logic [XLEN-1:0]  idRd2,
  input  logic [XLEN-1:0]  idImm,
  input  logic [REG_W-1:0] idDest,
  input  logic             idRegDst,
  input  logic [1:0]       idAluOp,
  input  logic             idAluSrc,
  input  logic             idBranch,
  input  logic             idMemRead,
  input  logic             idMemWrite,
  input  logic             idMemToReg,
  input  logic             idRegWrite,
  input  logic [XLEN-1:0]  exTarget,
  input  logic             exZero,
  input  logic [XLEN-1:0]  exAluResult,
  input  logic [XLEN-1:0]  memReadData,
  output logic [XLEN-1:0]  pcOut,
  output logic [XLEN-1:0]  ifIdInstr,
  output logic [XLEN-1:0]  ifIdPc,
  output logic [XLEN-1:0]  idExRd1,
  output logic [XLEN-1:0]  idExRd2,
  output logic [XLEN-1:0]  idExImm,
  output logic [XLEN-1:0]  idExPc,
  output logic [REG_W-1:0] idExDest,
  output logic             idExRegDst,
  output logic [1:0]       idExAluOp,
  output logic             idExAluSrc,
  output logic             idExBranch,
  output logic             idExMemRead,
  output logic             idExMemWrite,
  output logic             idExMemToReg,
  output logic             idExRegWrite,
  output logic [XLEN-1:0]  exMemTarget,
  output logic             exMemZero,
  output logic [XLEN-1:0]  exMemAluResult,
  output logic [XLEN-1:0]  exMemWriteData,
  output logic [REG_W-1:0] exMemDest,
  output logic             exMemBranch,
  output logic             exMemMemRead,
  output logic             exMemMemWrite,
  output logic             exMemMemToReg,
  output logic             exMemRegWrite,
  output logic [XLEN-1:0]  memWbReadData,
  output logic [XLEN-1:0]  memWbAluResult,
  output logic [REG_W-1:0] memWbDest,
  output logic             memWbMemToReg,
  output logic             memWbRegWrite
);

  stageStrobe_t strobe;
  idExCtrl_t    decCtrl;
  idExCtrl_t    idExCtrl;
  exMemCtrl_t   exMemCtrl;
  wbCtrl_t      memWbCtrl;

  assign decCtrl = '{
    ex:  '{regDst: idRegDst, aluOp: idAluOp, aluSrc: idAluSrc},
    mem: '{branch: idBranch, memRead: idMemRead, memWrite: idMemWrite},
    wb:  '{memToReg: idMemToReg, regWrite: idRegWrite}
  };

  pipeCtrlRegs u_ctrl (
    .clk(clk), .rstN(rstN), .pcEn(pcEn),
    .ifIdEn(ifIdEn), .ifIdFlush(ifIdFlush),
    .idExEn(idExEn), .idExFlush(idExFlush),
    .exMemEn(exMemEn), .exMemFlush(exMemFlush),
    .memWbEn(memWbEn), .memWbFlush(memWbFlush),
    .decCtrl(decCtrl), .strobe(strobe),
    .idExCtrl(idExCtrl), .exMemCtrl(exMemCtrl), .memWbCtrl(memWbCtrl)
  );

  pipeDataRegs #(
    .XLEN(XLEN), .REG_W(REG_W), .PC_STEP(PC_STEP), .RESET_PC(RESET_PC)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pcSrc(pcSrc), .branchTarget(branchTarget), .fetchInstr(fetchInstr),
    .idRd1(idRd1), .idRd2(idRd2), .idImm(idImm), .idDest(idDest),
    .exTarget(exTarget), .exZero(exZero), .exAluResult(exAluResult),
    .memReadData(memReadData),
    .pcOut(pcOut), .ifIdInstr(ifIdInstr), .ifIdPc(ifIdPc),
    .idExRd1(idExRd1), .idExRd2(idExRd2), .idExImm(idExImm),
    .idExPc(idExPc), .idExDest(idExDest),
    .exMemTarget(exMemTarget), .exMemZero(exMemZero),
    .exMemAluResult(exMemAluResult), .exMemWriteData(exMemWriteData),
    .exMemDest(exMemDest),
    .memWbReadData(memWbReadData), .memWbAluResult(memWbAluResult),
    .memWbDest(memWbDest)
  );

  assign idExRegDst    = idExCtrl.ex.regDst;
  assign idExAluOp     = idExCtrl.ex.aluOp;
  assign idExAluSrc    = idExCtrl.ex.aluSrc;
  assign idExBranch    = idExCtrl.mem.branch;
  assign idExMemRead   = idExCtrl.mem.memRead;
  assign idExMemWrite  = idExCtrl.mem.memWrite;
  assign idExMemToReg  = idExCtrl.wb.memToReg;
  assign idExRegWrite  = idExCtrl.wb.regWrite;
  assign exMemBranch   = exMemCtrl.mem.branch;
  assign exMemMemRead  = exMemCtrl.mem.memRead;
  assign exMemMemWrite = exMemCtrl.mem.memWrite;
  assign exMemMemToReg = exMemCtrl.wb.memToReg;
  assign exMemRegWrite = exMemCtrl.wb.regWrite;
  assign memWbMemToReg = memWbCtrl.memToReg;
  assign memWbRegWrite = memWbCtrl.regWrite;

endmodule

// File: rtl/pipeRegChainChk.sv
module pipeRegChainChk #(
  parameter int XLEN    = 32,
  parameter int REG_W   = 5,
  parameter int PC_STEP = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             pcEn,
  input logic             pcSrc,
  input logic [XLEN-1:0]  branchTarget,
  input logic [XLEN-1:0]  pcOut,
  input logic             ifIdFlush,
  input logic [XLEN-1:0]  ifIdInstr,
  input logic             idExEn,
  input logic             idExFlush,
  input logic [XLEN-1:0]  idExRd1,
  input logic [REG_W-1:0] idExDest,
  input logic             idExRegDst,
  input logic [1:0]       idExAluOp,
  input logic             idExAluSrc,
  input logic             idExBranch,
  input logic             idExMemRead,
  input logic             idExMemWrite,
  input logic             idExMemToReg,
  input logic             idExRegWrite,
  input logic             exMemEn,
  input logic             exMemFlush,
  input logic             exMemMemRead,
  input logic             exMemRegWrite,
  input logic [REG_W-1:0] exMemDest,
  input logic             memWbEn,
  input logic             memWbFlush,
  input logic [REG_W-1:0] memWbDest,
  input logic             memWbMemToReg,
  input logic             memWbRegWrite
);

  localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    pcEn && !pcSrc |=> pcOut == $past(pcOut) + STEP); // R1

  AST_PC_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    pcEn && pcSrc |=> pcOut == $past(branchTarget)); // R1

  AST_IFID_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    ifIdFlush |=> ifIdInstr == '0); // R9

  AST_IDEX_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    idExFlush |=> {idExRegDst, idExAluOp, idExAluSrc, idExBranch, idExMemRead,
                   idExMemWrite, idExMemToReg, idExRegWrite} == '0); // R8

  AST_IDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !idExEn && !idExFlush |=> $stable(idExRd1) && $stable(idExDest)
                              && $stable(idExRegWrite)); // R7

  AST_CTRL_RIDES: assert property (@(posedge clk) disable iff (!rstN)
    exMemEn && !exMemFlush |=> exMemRegWrite == $past(idExRegWrite)
                               && exMemMemRead == $past(idExMemRead)); // R6

  AST_MEMWB_BUBBLE: assert property (@(posedge clk) disable iff (!rstN)
    memWbFlush |=> !memWbRegWrite && !memWbMemToReg); // R8

  AST_DEST_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    memWbEn |=> memWbDest == $past(exMemDest)); // R5

endmodule

bind pipeRegChain pipeRegChainChk #(
  .XLEN(XLEN), .REG_W(REG_W), .PC_STEP(PC_STEP)
) u_chk (.*);

// File: tb/pipeRegChain_bench.sv
`timescale 1ns/1ps
module pipeRegChain_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic pcEn, pcSrc, ifIdEn, ifIdFlush, idExEn, idExFlush;
  logic exMemEn, exMemFlush, memWbEn, memWbFlush;
  logic [31:0] branchTarget, fetchInstr, idRd1, idRd2, idImm;
  logic [31:0] exTarget, exAluResult, memReadData;
  logic [4:0]  idDest;
  logic        exZero;
  logic [8:0]  dCtl; // {regDst, aluOp[1:0], aluSrc, branch, memRead, memWrite, memToReg, regWrite}

  logic [31:0] pcOut, ifIdInstr, ifIdPc, idExRd1, idExRd2, idExImm, idExPc;
  logic [4:0]  idExDest, exMemDest, memWbDest;
  logic        idExRegDst, idExAluSrc, idExBranch, idExMemRead, idExMemWrite;
  logic        idExMemToReg, idExRegWrite;
  logic [1:0]  idExAluOp;
  logic [31:0] exMemTarget, exMemAluResult, exMemWriteData;
  logic        exMemZero, exMemBranch, exMemMemRead, exMemMemWrite;
  logic        exMemMemToReg, exMemRegWrite;
  logic [31:0] memWbReadData, memWbAluResult;
  logic        memWbMemToReg, memWbRegWrite;

  pipeRegChain u_pipeRegChain (
    .clk(clk), .rstN(rstN), .pcEn(pcEn), .pcSrc(pcSrc),
    .branchTarget(branchTarget), .ifIdEn(ifIdEn), .ifIdFlush(ifIdFlush),
    .idExEn(idExEn), .idExFlush(idExFlush), .exMemEn(exMemEn),
    .exMemFlush(exMemFlush), .memWbEn(memWbEn), .memWbFlush(memWbFlush),
    .fetchInstr(fetchInstr), .idRd1(idRd1), .idRd2(idRd2), .idImm(idImm),
    .idDest(idDest), .idRegDst(dCtl[8]), .idAluOp(dCtl[7:6]),
    .idAluSrc(dCtl[5]), .idBranch(dCtl[4]), .idMemRead(dCtl[3]),
    .idMemWrite(dCtl[2]), .idMemToReg(dCtl[1]), .idRegWrite(dCtl[0]),
    .exTarget(exTarget), .exZero(exZero), .exAluResult(exAluResult),
    .memReadData(memReadData),
    .pcOut(pcOut), .ifIdInstr(ifIdInstr), .ifIdPc(ifIdPc),
    .idExRd1(idExRd1), .idExRd2(idExRd2), .idExImm(idExImm),
    .idExPc(idExPc), .idExDest(idExDest), .idExRegDst(idExRegDst),
    .idExAluOp(idExAluOp), .idExAluSrc(idExAluSrc), .idExBranch(idExBranch),
    .idExMemRead(idExMemRead), .idExMemWrite(idExMemWrite),
    .idExMemToReg(idExMemToReg), .idExRegWrite(idExRegWrite),
    .exMemTarget(exMemTarget), .exMemZero(exMemZero),
    .exMemAluResult(exMemAluResult), .exMemWriteData(exMemWriteData),
    .exMemDest(exMemDest), .exMemBranch(exMemBranch),
    .exMemMemRead(exMemMemRead), .exMemMemWrite(exMemMemWrite),
    .exMemMemToReg(exMemMemToReg), .exMemRegWrite(exMemRegWrite),
    .memWbReadData(memWbReadData), .memWbAluResult(memWbAluResult),
    .memWbDest(memWbDest), .memWbMemToReg(memWbMemToReg),
    .memWbRegWrite(memWbRegWrite)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] ePc = '0, eIfInstr = '0, eIfPc = '0;
  logic [31:0] eIdRd1 = '0, eIdRd2 = '0, eIdImm = '0, eIdPc = '0;
  logic [4:0]  eIdDest = '0, eExDest = '0, eWbDest = '0;
  logic [8:0]  eIdCtl = '0;
  logic [31:0] eExTarget = '0, eExRes = '0, eExWd = '0;
  logic        eExZero = 1'b0;
  logic [4:0]  eExCtl = '0;
  logic [31:0] eWbRd = '0, eWbRes = '0;
  logic [1:0]  eWbCtl = '0;

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string pcTag, input string ifTag, input string idTag,
                            input string exTag, input string wbTag);
    chk(pcTag, {128'b0, pcOut}, {128'b0, ePc});
    chk(ifTag, {96'b0, ifIdInstr, ifIdPc}, {96'b0, eIfInstr, eIfPc});
    chk(idTag, {9'b0, idExRd1, idExRd2, idExImm, idExPc, idExDest,
                idExRegDst, idExAluOp, idExAluSrc, idExBranch, idExMemRead,
                idExMemWrite, idExMemToReg, idExRegWrite},
               {9'b0, eIdRd1, eIdRd2, eIdImm, eIdPc, eIdDest, eIdCtl});
    chk(exTag, {48'b0, exMemTarget, exMemZero, exMemAluResult, exMemWriteData,
                exMemDest, exMemBranch, exMemMemRead, exMemMemWrite,
                exMemMemToReg, exMemRegWrite},
               {48'b0, eExTarget, eExZero, eExRes, eExWd, eExDest, eExCtl});
    chk(wbTag, {89'b0, memWbReadData, memWbAluResult, memWbDest,
                memWbMemToReg, memWbRegWrite},
               {89'b0, eWbRd, eWbRes, eWbDest, eWbCtl});
  endtask

  // model update from the requirements, back to front so old values are used
  task automatic stepModel();
    if (memWbEn) begin
      eWbRd = memReadData; eWbRes = eExRes; eWbDest = eExDest;
    end
    if (memWbFlush)   eWbCtl = '0;
    else if (memWbEn) eWbCtl = eExCtl[1:0];
    if (exMemEn) begin
      eExTarget = exTarget; eExZero = exZero; eExRes = exAluResult;
      eExWd = eIdRd2; eExDest = eIdDest;
    end
    if (exMemFlush)   eExCtl = '0;
    else if (exMemEn) eExCtl = eIdCtl[4:0];
    if (idExEn) begin
      eIdRd1 = idRd1; eIdRd2 = idRd2; eIdImm = idImm; eIdPc = eIfPc; eIdDest = idDest;
    end
    if (idExFlush)   eIdCtl = '0;
    else if (idExEn) eIdCtl = dCtl;
    if (ifIdFlush)   eIfInstr = '0;
    else if (ifIdEn) eIfInstr = fetchInstr;
    if (ifIdEn)      eIfPc = ePc + 32'd4;
    if (pcEn)        ePc = pcSrc ? branchTarget : ePc + 32'd4;
  endtask

  initial begin
    {pcEn, pcSrc, ifIdEn, ifIdFlush, idExEn, idExFlush} = '1;
    {exMemEn, exMemFlush, memWbEn, memWbFlush} = '1;
    branchTarget = 32'h1234_5678; fetchInstr = 32'hDEAD_BEEF;
    idRd1 = '1; idRd2 = '1; idImm = '1; idDest = '1; dCtl = '1;
    exTarget = '1; exZero = 1'b1; exAluResult = '1; memReadData = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state with every input active
    compareAll("R10", "R10", "R10", "R10", "R10");
    rstN = 1'b1;

    for (int k = 0; k < 2048; k++) begin
      logic [9:0] c;
      logic [31:0] h;
      c = k[9:0];
      h = k * 32'h9E37_79B9 + 32'h0F0F_1357;
      pcEn = c[0]; pcSrc = c[1]; ifIdEn = c[2]; ifIdFlush = c[3];
      idExEn = c[4]; idExFlush = c[5]; exMemEn = c[6]; exMemFlush = c[7];
      memWbEn = c[8]; memWbFlush = c[9];
      branchTarget = {h[31:2], 2'b00} ^ 32'h0040_0000;
      fetchInstr   = h ^ 32'h5555_0000;
      idRd1        = h + 32'h0101_0101;
      idRd2        = ~h;
      idImm        = {h[15] ? 16'hFFFF : 16'h0000, h[15:0]};
      idDest       = h[8:4] ^ 5'(k);
      dCtl         = 9'(h[20:12] ^ 9'(k));
      exTarget     = h * 32'd3;
      exZero       = h[7] ^ k[10];
      exAluResult  = h ^ 32'hA5A5_A5A5;
      memReadData  = h + 32'h7777_0000;
      stepModel();
      @(negedge clk);
      compareAll("R1", "R2/R7/R9", "R3/R6/R7/R8", "R4/R6/R7/R8", "R5/R6/R7/R8");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule